// File: doc/BRIEF.md
# SECDED Read Check and Correct

This block sits on the read return path of a static memory controller. Each returned word carries 32 data bits and a 7-bit check code. The block recomputes the check code from the data and XORs it with the stored code to form a syndrome. It sorts the result into three classes: clean, a single-bit fault that can be repaired, or a multi-bit fault that cannot. One clock later it presents the word, repaired where allowed, with a valid strobe.

Three separate enables control the block. One permits repair of single-bit faults. A second raises an interrupt request for single-bit faults, so software can scrub the location. A third raises an interrupt request for multi-bit faults. A multi-bit fault on an ordinary read aborts the bus transfer. A multi-bit fault on the read half of a read-modify-write does not abort. In both cases the fault class is exported to the read-modify-write sequencer.

The address and class of the first faulty access are held until software clears them. A sticky overflow flag records any fault that arrives while that record is full.

Top module: `secded_rd_check`

## Requirements
- R1: Every cycle with `in_valid` high yields exactly one cycle of `out_valid` high on the next clock edge, and `out_valid` is low otherwise.
- R2: Data bit i uses the i-th 7-bit value of weight three, counting upward from 0. Check bit j uses the unit vector with only bit j set. The syndrome is the XOR of the stored check bits with the code recomputed from the read data.
- R3: A zero syndrome gives class 2'b00 (none) on `out_err_class`, and `out_data` equals the read data.
- R4: A syndrome equal to the column of data bit i gives class 2'b01 (single). When `cfg_corr_en` is high, bit i of `out_data` is inverted.
- R5: A syndrome equal to a unit vector (a check-bit fault) gives class 2'b01, and `out_data` equals the read data.
- R6: With `cfg_corr_en` low, a single-bit data fault is still reported as class 2'b01, but `out_data` carries the raw read data.
- R7: A nonzero syndrome that matches no column gives class 2'b10 (multi), and `out_data` carries the raw read data.
- R8: `out_abort` is high with `out_valid` exactly when the class is 2'b10 and `in_rmw` was low for that word. It is never high for a read-modify-write read.
- R9: `irq_single` pulses with `out_valid` for class 2'b01 only if `cfg_sbe_rpt_en` is set. `irq_multi` pulses for class 2'b10 only if `cfg_mbe_rpt_en` is set.
- R10: When no record is held, a faulty word loads `err_addr` and `err_type` and sets `err_held` on the same edge that presents the word. While `err_held` is set, those registers do not change.
- R11: A fault arriving while `err_held` is set sets `err_overflow`, which stays set. A `clr_status` pulse clears `err_held` and `err_overflow`. A fault arriving in the same cycle as the clear is recorded as a new first fault.
- R12: After reset, all outputs and the error record are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Read word present |
| in_data | input | 32 | Data bits read from memory |
| in_chk | input | 7 | Check bits read from memory |
| in_addr | input | 16 | Address of the access |
| in_rmw | input | 1 | Read belongs to a read-modify-write |
| cfg_corr_en | input | 1 | Allow single-bit repair |
| cfg_sbe_rpt_en | input | 1 | Interrupt on single-bit faults |
| cfg_mbe_rpt_en | input | 1 | Interrupt on multi-bit faults |
| clr_status | input | 1 | Write-one-to-clear pulse for the error record |
| out_valid | output | 1 | Output word valid |
| out_data | output | 32 | Repaired or raw data |
| out_err_class | output | 2 | Fault class for the sequencer |
| out_abort | output | 1 | Abort the bus read |
| irq_single | output | 1 | Single-bit interrupt request pulse |
| irq_multi | output | 1 | Multi-bit interrupt request pulse |
| err_addr | output | 16 | Address of the first recorded fault |
| err_type | output | 2 | Class of the first recorded fault |
| err_held | output | 1 | A fault record is held |
| err_overflow | output | 1 | A later fault arrived while a record was held |

## Verification
The assertions assume that the data, check and address inputs are known (not X) in every cycle in which `in_valid` is high. They also assume that `in_valid` stays low while reset is active. The bench keeps to this by driving every input to a defined value before releasing reset, and by changing inputs only on the falling clock edge. Each faulty word is built from a correctly encoded word by inverting chosen bit positions, so the syndrome always corresponds to a known fault pattern.

// File: rtl/secded_pkg.sv
package secded_pkg;

   typedef enum logic [1:0] {
      CLS_NONE   = 2'b00,
      CLS_SINGLE = 2'b01,
      CLS_MULTI  = 2'b10
   } err_class_e;

   function automatic int popcnt(input int v, input int bits);
      int n;
      n = 0;
      for (int b = 0; b < bits; b++) n += (v >> b) & 1;
      return n;
   endfunction

   // Column for data bit idx: odd weights from 3 upward, ascending values within a weight.
   function automatic int data_col(input int idx, input int chk_w);
      int n;
      n = 0;
      for (int w = 3; w <= chk_w; w += 2)
         for (int v = 0; v < (1 << chk_w); v++)
            if (popcnt(v, chk_w) == w) begin
               if (n == idx) return v;
               n++;
            end
      return 0;
   endfunction

   function automatic int col_supply(input int chk_w);
      int n;
      n = 0;
      for (int v = 0; v < (1 << chk_w); v++)
         if (popcnt(v, chk_w) >= 3 && popcnt(v, chk_w) % 2 == 1) n++;
      return n;
   endfunction

endpackage

// File: rtl/secded_syndrome.sv
module secded_syndrome #(
   parameter int DATA_W = 32,
   parameter int CHK_W  = 7
) (
   input  logic [DATA_W-1:0] data_i,
   input  logic [CHK_W-1:0]  chk_i,
   output logic [CHK_W-1:0]  syn_o
);
   logic [CHK_W-1:0] gen_chk;

   for (genvar j = 0; j < CHK_W; j++) begin : g_row
      logic [DATA_W-1:0] row_mask;
      for (genvar i = 0; i < DATA_W; i++) begin : g_bit
         localparam int COL = secded_pkg::data_col(i, CHK_W);
         assign row_mask[i] = ((COL >> j) & 1) == 1;
      end
      assign gen_chk[j] = ^(data_i & row_mask);
   end

   assign syn_o = gen_chk ^ chk_i;
endmodule

// File: rtl/secded_decode.sv
module secded_decode #(
   parameter int DATA_W = 32,
   parameter int CHK_W  = 7
) (
   input  logic [CHK_W-1:0]  syn_i,
   output logic [DATA_W-1:0] flip_o,
   output logic              chk_hit_o,
   output secded_pkg::err_class_e cls_o
);
   for (genvar i = 0; i < DATA_W; i++) begin : g_match
      localparam logic [CHK_W-1:0] COL = CHK_W'(secded_pkg::data_col(i, CHK_W));
      assign flip_o[i] = (syn_i == COL);
   end

   assign chk_hit_o = $onehot(syn_i);

   always_comb begin
      if (syn_i == '0)                 cls_o = secded_pkg::CLS_NONE;
      else if (|flip_o || chk_hit_o)   cls_o = secded_pkg::CLS_SINGLE;
      else                             cls_o = secded_pkg::CLS_MULTI;
   end
endmodule

// File: rtl/secded_err_log.sv
module secded_err_log #(
   parameter int ADDR_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              hit_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [1:0]        cls_i,
   input  logic              clr_i,
   output logic [ADDR_W-1:0] err_addr_o,
   output logic [1:0]        err_type_o,
   output logic              held_o,
   output logic              ovf_o
);
   logic held_eff;
   assign held_eff = held_o && !clr_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         err_addr_o <= '0;
         err_type_o <= '0;
         held_o     <= 1'b0;
         ovf_o      <= 1'b0;
      end else begin
         held_o <= held_eff || hit_i;
         ovf_o  <= (ovf_o && !clr_i) || (hit_i && held_eff);
         if (hit_i && !held_eff) begin
            err_addr_o <= addr_i;
            err_type_o <= cls_i;
         end
      end
   end

   a_r10_record_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      held_o && !clr_i |=> $stable(err_addr_o) && $stable(err_type_o));
   a_r11_overflow_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      ovf_o && !clr_i |=> ovf_o);
   a_r11_clear_empties: assert property (@(posedge clk) disable iff (!rst_n)
      clr_i && !hit_i |=> !held_o && !ovf_o);
endmodule

// File: rtl/secded_rd_check.sv
module secded_rd_check #(
   parameter int DATA_W = 32,
   parameter int CHK_W  = 7,
   parameter int ADDR_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [DATA_W-1:0] in_data,
   input  logic [CHK_W-1:0]  in_chk,
   input  logic [ADDR_W-1:0] in_addr,
   input  logic              in_rmw,
   input  logic              cfg_corr_en,
   input  logic              cfg_sbe_rpt_en,
   input  logic              cfg_mbe_rpt_en,
   input  logic              clr_status,
   output logic              out_valid,
   output logic [DATA_W-1:0] out_data,
   output logic [1:0]        out_err_class,
   output logic              out_abort,
   output logic              irq_single,
   output logic              irq_multi,
   output logic [ADDR_W-1:0] err_addr,
   output logic [1:0]        err_type,
   output logic              err_held,
   output logic              err_overflow
);
   import secded_pkg::*;

   localparam int COL_SUPPLY = col_supply(CHK_W);

   if (COL_SUPPLY < DATA_W) begin : g_bad_code
      $error("secded_rd_check: too few odd-weight columns for DATA_W");
   end
   if (ADDR_W < 1) begin : g_bad_addr
      $error("secded_rd_check: ADDR_W must be positive");
   end

   logic [CHK_W-1:0]  syn;
   logic [DATA_W-1:0] flip;
   logic              chk_hit;
   err_class_e        cls;
   logic [DATA_W-1:0] fixed_data;
   logic              is_single, is_multi, hit;

   secded_syndrome #(.DATA_W(DATA_W), .CHK_W(CHK_W)) u_syn (
      .data_i(in_data), .chk_i(in_chk), .syn_o(syn));

   secded_decode #(.DATA_W(DATA_W), .CHK_W(CHK_W)) u_dec (
      .syn_i(syn), .flip_o(flip), .chk_hit_o(chk_hit), .cls_o(cls));

   assign is_single  = (cls == CLS_SINGLE);
   assign is_multi   = (cls == CLS_MULTI);
   assign hit        = in_valid && (cls != CLS_NONE);
   assign fixed_data = (cfg_corr_en && is_single) ? (in_data ^ flip) : in_data;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid     <= 1'b0;
         out_data      <= '0;
         out_err_class <= CLS_NONE;
         out_abort     <= 1'b0;
         irq_single    <= 1'b0;
         irq_multi     <= 1'b0;
      end else begin
         out_valid  <= in_valid;
         out_abort  <= in_valid && is_multi && !in_rmw;
         irq_single <= in_valid && is_single && cfg_sbe_rpt_en;
         irq_multi  <= in_valid && is_multi && cfg_mbe_rpt_en;
         if (in_valid) begin
            out_data      <= fixed_data;
            out_err_class <= cls;
         end
      end
   end

   secded_err_log #(.ADDR_W(ADDR_W)) u_log (
      .clk(clk), .rst_n(rst_n), .hit_i(hit), .addr_i(in_addr), .cls_i(cls),
      .clr_i(clr_status), .err_addr_o(err_addr), .err_type_o(err_type),
      .held_o(err_held), .ovf_o(err_overflow));

   a_r1_latency: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);
   a_r1_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !out_valid);
   a_r3_clean_passes: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && syn == '0 |=> out_data == $past(in_data) && out_err_class == 2'b00);
   a_r4_single_flip: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |-> $onehot0(flip));
   a_r5_chk_fault_keeps_data: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && chk_hit |=> out_data == $past(in_data));
   a_r8_abort_plain_read: assert property (@(posedge clk) disable iff (!rst_n)
      out_abort |-> out_valid && out_err_class == 2'b10 && !$past(in_rmw));
   a_r9_irq_with_valid: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_single || irq_multi) |-> out_valid && out_err_class != 2'b00);
endmodule

// File: tb/tb_secded_rd_check.sv
module tb_secded_rd_check;
   localparam int CLK_PERIOD = 10;
   localparam int NV = 10;
   localparam logic [5:0] NO = 6'd63;

   typedef struct packed {
      logic [31:0] d;
      logic [5:0]  p1;
      logic [5:0]  p2;
      logic        rmw;
      logic        corr;
      logic        sbe;
      logic        mbe;
   } vec_t;

   localparam vec_t VECS [NV] = '{
      '{32'hA5A5_0F0F, NO,    NO,    1'b0, 1'b1, 1'b1, 1'b1},
      '{32'h1234_5678, 6'd5,  NO,    1'b0, 1'b1, 1'b1, 1'b1},
      '{32'hFFFF_0000, 6'd31, NO,    1'b0, 1'b0, 1'b1, 1'b1},
      '{32'h0000_0000, 6'd33, NO,    1'b0, 1'b1, 1'b1, 1'b1},
      '{32'hDEAD_BEEF, 6'd3,  6'd17, 1'b0, 1'b1, 1'b1, 1'b1},
      '{32'hDEAD_BEEF, 6'd0,  6'd36, 1'b1, 1'b1, 1'b1, 1'b1},
      '{32'hCAFE_F00D, 6'd10, 6'd20, 1'b0, 1'b1, 1'b1, 1'b0},
      '{32'h8000_0001, 6'd31, NO,    1'b0, 1'b1, 1'b0, 1'b1},
      '{32'hFFFF_FFFF, NO,    NO,    1'b1, 1'b1, 1'b1, 1'b1},
      '{32'h0F0F_F0F0, 6'd38, NO,    1'b0, 1'b1, 1'b1, 1'b1}
   };

   logic clk = 1'b0, rst_n = 1'b0;
   logic in_valid = 1'b0, in_rmw = 1'b0, clr_status = 1'b0;
   logic cfg_corr_en = 1'b0, cfg_sbe_rpt_en = 1'b0, cfg_mbe_rpt_en = 1'b0;
   logic [31:0] in_data = '0;
   logic [6:0]  in_chk = '0;
   logic [15:0] in_addr = '0;
   logic out_valid, out_abort, irq_single, irq_multi, err_held, err_overflow;
   logic [31:0] out_data;
   logic [1:0]  out_err_class, err_type;
   logic [15:0] err_addr;

   int n_chk = 0, n_bad = 0;
   logic [6:0] cols [32];

   secded_rd_check dut (.*);

   always #(CLK_PERIOD/2) clk = ~clk;

   function automatic logic [6:0] encode(input logic [31:0] d);
      logic [6:0] c;
      c = '0;
      for (int i = 0; i < 32; i++) if (d[i]) c ^= cols[i];
      return c;
   endfunction

   task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic apply(input logic [31:0] d, input logic [6:0] c, input logic [15:0] a,
                        input logic rmw, input logic corr, input logic sbe, input logic mbe,
                        input logic clr);
      @(negedge clk);
      in_valid = 1'b1; in_data = d; in_chk = c; in_addr = a; in_rmw = rmw;
      cfg_corr_en = corr; cfg_sbe_rpt_en = sbe; cfg_mbe_rpt_en = mbe; clr_status = clr;
      @(negedge clk);
      in_valid = 1'b0; clr_status = 1'b0;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      logic exp_held, exp_ovf;
      logic [15:0] exp_addr;
      logic [1:0]  exp_type;
      begin
         int n;
         n = 0;
         for (int v = 0; v < 128 && n < 32; v++)
            if ($countones(7'(v)) == 3) begin cols[n] = 7'(v); n++; end
      end
      repeat (3) @(negedge clk);
      // R12: reset state
      check(out_valid == 0 && out_data == 0 && out_err_class == 0 && out_abort == 0 &&
            irq_single == 0 && irq_multi == 0, "R12 outputs in reset", {out_valid, out_data}, 0);
      check(err_held == 0 && err_overflow == 0 && err_addr == 0 && err_type == 0,
            "R12 record in reset", {err_held, err_overflow, err_addr}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      check(out_valid == 0, "R1 idle no valid", out_valid, 0);

      exp_held = 0; exp_ovf = 0; exp_addr = 0; exp_type = 0;
      for (int k = 0; k < NV; k++) begin
         vec_t v;
         logic [38:0] cw;
         logic [31:0] exp_d;
         logic [1:0]  exp_c;
         int nf;
         v  = VECS[k];
         cw = {encode(v.d), v.d};
         nf = 0;
         if (v.p1 != NO) begin cw[v.p1] = ~cw[v.p1]; nf++; end
         if (v.p2 != NO) begin cw[v.p2] = ~cw[v.p2]; nf++; end
         exp_c = (nf == 0) ? 2'b00 : (nf == 1) ? 2'b01 : 2'b10;
         exp_d = (nf == 1 && v.p1 < 32 && v.corr) ? v.d : cw[31:0];
         apply(cw[31:0], cw[38:32], 16'h0100 + 16'(k), v.rmw, v.corr, v.sbe, v.mbe, 1'b0);
         if (exp_c != 0) begin
            if (exp_held) exp_ovf = 1;
            else begin exp_held = 1; exp_addr = 16'h0100 + 16'(k); exp_type = exp_c; end
         end
         check(out_valid == 1, "R1 valid after one cycle", out_valid, 1);
         check(out_err_class == exp_c, "R3 R4 R5 R7 class", out_err_class, exp_c);
         check(out_data == exp_d, "R4 R5 R6 R7 data", out_data, exp_d);
         check(out_abort == (exp_c == 2 && !v.rmw), "R8 abort", out_abort, (exp_c == 2 && !v.rmw));
         check(irq_single == (exp_c == 1 && v.sbe), "R9 irq single", irq_single, (exp_c == 1 && v.sbe));
         check(irq_multi == (exp_c == 2 && v.mbe), "R9 irq multi", irq_multi, (exp_c == 2 && v.mbe));
         check(err_held == exp_held && err_addr == exp_addr && err_type == exp_type,
               "R10 record", {err_held, err_type, err_addr}, {exp_held, exp_type, exp_addr});
         check(err_overflow == exp_ovf, "R11 overflow", err_overflow, exp_ovf);
      end

      // R2: every data-bit column is corrected at its own position
      for (int b = 0; b < 32; b++) begin
         logic [31:0] d;
         d = 32'h5A5A_3C3C;
         apply(d ^ (32'h1 << b), encode(d), 16'h0200, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
         check(out_data == d && out_err_class == 2'b01, "R2 column position", out_data, d);
      end

      // R11: a clear on its own empties the record
      @(negedge clk); clr_status = 1'b1;
      @(negedge clk); clr_status = 1'b0;
      check(err_held == 0 && err_overflow == 0, "R11 clear", {err_held, err_overflow}, 0);

      // R11: a fault arriving in the clear cycle becomes the new first record
      apply(32'h0000_0001, encode(32'h0), 16'h0ABC, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1);
      check(err_held == 1 && err_addr == 16'h0ABC && err_type == 2'b01 && err_overflow == 0,
            "R11 clear with fault", {err_held, err_overflow, err_addr}, {2'b10, 16'h0ABC});

      // R10/R11: a following multi-bit fault sets overflow and leaves the record alone
      apply(32'h0000_0003, encode(32'h0), 16'h0DEF, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0);
      check(err_addr == 16'h0ABC && err_type == 2'b01, "R10 record kept", {err_type, err_addr}, {2'b01, 16'h0ABC});
      check(err_overflow == 1, "R11 overflow set", err_overflow, 1);
      check(out_abort == 0 && out_err_class == 2'b10, "R8 no abort on rmw", out_abort, 0);

      // R1: valid lasts one cycle
      @(negedge clk);
      check(out_valid == 0, "R1 valid single pulse", out_valid, 0);

      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule